// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller with Block Management

This block keeps the tag and state side of a set-associative data cache. There is no data array. Each request brings an address and an operation. The address is split into tag, set index and byte offset, and the tags of every way in the indexed set are compared. The block then updates the valid bits, the dirty bits and a per-set tree pseudo-LRU. One cycle after the request is accepted, it returns an outcome code together with the way that was touched.

Besides ordinary reads and writes, four cache-block management operations are recognised: zero, invalidate, clean and flush. Each one has its own rule for changing the line state. When a miss needs a victim, the outcome code tells the caller whether that line must be written back before it is reused. Moving the data and the writeback itself are the caller's job. A separate command clears the whole cache.

Top module: `cache_tag_ctrl`

## Requirements
- R1: Address fields: bits [OFF_W-1:0] are the byte offset and are ignored. The next SET_W bits select the set, and the remaining upper bits form the tag. Two addresses that differ only in the offset refer to the same line.
- R2: A request hits when some way of the indexed set is valid and holds the request tag. Outcome codes are 2'b00 hit, 2'b01 miss, 2'b10 clean eviction and 2'b11 eviction needing writeback. At most one way may match.
- R3: A write hit (req_write=1, or the zero operation) sets the line's dirty bit. A read hit leaves the dirty bit unchanged. The dirty state can be observed later through the eviction code.
- R4: Replacement uses a tree pseudo-LRU with nodes 1..WAYS-1. Node 1 is the root, and the children of node n are 2n (lower half) and 2n+1 (upper half). A node bit of 0 points the victim search to the lower half. Touching way w sets every node on w's path to point away from w. Hits and allocations touch the way.
- R5: On an allocating miss with an invalid way in the set, the lowest-numbered invalid way is filled. The code is 01, rsp_way reports that way, and it is touched.
- R6: On an allocating miss with all ways valid, the way reached by following the pseudo-LRU bits is replaced. The code is 11 if that way was dirty, otherwise 10. The new line is dirty exactly when the request writes.
- R7: Clean (req_cmo=4'b0010): on a hit the line's dirty bit is cleared and the way is touched. On a miss the code is 01 and nothing changes.
- R8: Invalidate (req_cmo=4'b0001) and flush (req_cmo=4'b0100): on a hit the code is 00 and the line's valid and dirty bits are cleared, with the pseudo-LRU left as it was. On a miss the code is 01 and nothing changes.
- R9: Zero (req_cmo=4'b1000) behaves as a write: it sets dirty on a hit and allocates on a miss. req_cmo=4'b0000 selects a plain access, and at most one bit of req_cmo may be set.
- R10: While inv_all is high, req_ready is low. On that edge every valid and dirty bit in every set and way is cleared.
- R11: A request is accepted when req_valid and req_ready are both high. rsp_valid is high in exactly the following cycle, with rsp_code and rsp_way. After reset every line is invalid, every pseudo-LRU tree is zero, rsp_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | Store or atomic (ignored when a management operation is given) |
| req_cmo | input | 4 | One-hot management operation, 0 for a plain access |
| inv_all | input | 1 | Clear every line of the cache |
| rsp_valid | output | 1 | Outcome valid |
| rsp_code | output | 2 | Outcome code |
| rsp_way | output | $clog2(WAYS) | Way hit, filled, replaced or killed |

## Verification
The assertions check on every cycle that:
- no dirty line is invalid;
- no two ways match one tag;
- an accepted request always produces a response;
- a killed line is gone one cycle later;
- a whole-cache clear leaves no valid line.

Correct pseudo-LRU victim order, the writeback decision after a chain of dirty and clean transitions, and the no-allocation rule for clean, invalidate and flush misses only show up in the bench's directed and random sequences. Those sequences compare every outcome and way against a reference model.

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_write,
  input  logic [3:0]              req_cmo,
  input  logic                    inv_all,
  output logic                    rsp_valid,
  output logic [1:0]              rsp_code,
  output logic [$clog2(WAYS)-1:0] rsp_way
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;
  localparam int WAY_W = $clog2(WAYS);

  localparam logic [1:0] C_HIT = 2'b00, C_MISS = 2'b01, C_EVC = 2'b10, C_EVWB = 2'b11;

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  val_q [SETS];
  logic [WAYS-1:0]  dty_q [SETS];
  logic [WAYS-1:1]  lru_q [SETS];

  logic [SET_W-1:0] set_i;
  logic [TAG_W-1:0] tag_i;
  logic             unused_off;
  assign set_i      = req_addr[OFF_W +: SET_W];
  assign tag_i      = req_addr[ADDR_W-1 -: TAG_W];
  assign unused_off = ^req_addr[OFF_W-1:0];

  function automatic logic [WAY_W-1:0] plru_pick(input logic [WAYS-1:1] t);
    int n = 1;
    for (int l = 0; l < WAY_W; l++) n = 2 * n + int'(t[n]);
    return WAY_W'(n - WAYS);
  endfunction

  function automatic logic [WAYS-1:1] plru_touch(input logic [WAYS-1:1] t,
                                                  input logic [WAY_W-1:0] w);
    int n = 1;
    for (int l = 0; l < WAY_W; l++) begin
      t[n] = ~w[WAY_W-1-l];
      n    = 2 * n + int'(w[WAY_W-1-l]);
    end
    return t;
  endfunction

  logic             fire, hit, full, is_wr, kill, clean, noalloc;
  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_idx, free_idx, victim, way;
  logic [1:0]       code;

  assign req_ready = ~inv_all;
  assign fire      = req_valid & req_ready;
  assign noalloc   = |req_cmo[2:0];
  assign kill      = req_cmo[0] | req_cmo[2];
  assign clean     = req_cmo[1];
  assign is_wr     = (req_write & ~noalloc) | req_cmo[3];
  assign hit       = |hit_vec;
  assign full      = &val_q[set_i];
  assign victim    = plru_pick(lru_q[set_i]);

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = val_q[set_i][w] && (tag_q[set_i][w] == tag_i);
      if (hit_vec[w]) hit_idx = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--)
      if (!val_q[set_i][w]) free_idx = WAY_W'(w);
    if (hit) begin
      code = C_HIT;  way = hit_idx;
    end else if (noalloc) begin
      code = C_MISS; way = '0;
    end else if (!full) begin
      code = C_MISS; way = free_idx;
    end else begin
      code = dty_q[set_i][victim] ? C_EVWB : C_EVC;
      way  = victim;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= C_HIT;
      rsp_way   <= '0;
      for (int s = 0; s < SETS; s++) begin
        val_q[s] <= '0;
        dty_q[s] <= '0;
        lru_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
      end
    end else begin
      rsp_valid <= fire;
      if (fire) begin
        rsp_code <= code;
        rsp_way  <= way;
      end
      if (inv_all) begin
        for (int s = 0; s < SETS; s++) begin
          val_q[s] <= '0;
          dty_q[s] <= '0;
        end
      end else if (fire) begin
        if (hit) begin
          if (kill) begin
            val_q[set_i][hit_idx] <= 1'b0;
            dty_q[set_i][hit_idx] <= 1'b0;
          end else begin
            lru_q[set_i] <= plru_touch(lru_q[set_i], hit_idx);
            if (clean)      dty_q[set_i][hit_idx] <= 1'b0;
            else if (is_wr) dty_q[set_i][hit_idx] <= 1'b1;
          end
        end else if (!noalloc) begin
          tag_q[set_i][way] <= tag_i;
          val_q[set_i][way] <= 1'b1;
          dty_q[set_i][way] <= is_wr;
          lru_q[set_i]      <= plru_touch(lru_q[set_i], way);
        end
      end
    end
  end

  logic any_valid, orphan_dirty;
  always_comb begin
    any_valid    = 1'b0;
    orphan_dirty = 1'b0;
    for (int s = 0; s < SETS; s++) begin
      any_valid    = any_valid | (|val_q[s]);
      orphan_dirty = orphan_dirty | (|(dty_q[s] & ~val_q[s]));
    end
  end

  // R2
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot0(hit_vec));
  // R9
  cmo_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot0(req_cmo));
  // R11
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R8
  kill_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && hit && kill) |=> !val_q[$past(set_i)][$past(hit_idx)]);
  // R10
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !any_valid);
  // R3
  dirty_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !orphan_dirty);
endmodule

// File: tb/test_cache_tag_ctrl.sv
`timescale 1ns/1ps
module test_cache_tag_ctrl;
  localparam int ADDR_W = 32, WAYS = 4, SETS = 16, LINE_BYTES = 64;
  localparam int OFF_W = 6, SET_W = 4, TAG_W = ADDR_W - OFF_W - SET_W, WAY_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, inv_all = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0] req_cmo = '0;
  logic req_ready, rsp_valid;
  logic [1:0] rsp_code;
  logic [WAY_W-1:0] rsp_way;

  always #2.5 clk = ~clk;

  cache_tag_ctrl #(.ADDR_W(ADDR_W), .WAYS(WAYS), .SETS(SETS), .LINE_BYTES(LINE_BYTES))
    i_cache_tag_ctrl (.clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_write,
                      .req_cmo, .inv_all, .rsp_valid, .rsp_code, .rsp_way);

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  bit [TAG_W-1:0] m_tag [SETS][WAYS];
  bit             m_val [SETS][WAYS];
  bit             m_dty [SETS][WAYS];
  bit [WAYS-1:1]  m_lru [SETS];

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int m_victim(input int s);
    int n = 1;
    for (int l = 0; l < WAY_W; l++) n = 2 * n + int'(m_lru[s][n]);
    return n - WAYS;
  endfunction

  function automatic void m_touch(input int s, input int w);
    int n = 1;
    for (int l = WAY_W - 1; l >= 0; l--) begin
      int b = (w >> l) & 1;
      m_lru[s][n] = (b == 0);
      n = 2 * n + b;
    end
  endfunction

  function automatic logic [31:0] mk(input int tg, input int s, input int off);
    return (32'(tg) << (OFF_W + SET_W)) | (32'(s) << OFF_W) | 32'(off);
  endfunction

  task automatic do_req(input logic [31:0] a, input logic wr, input logic [3:0] cmo,
                        input string lbl);
    int s = int'(a[OFF_W +: SET_W]);
    bit [TAG_W-1:0] t = a[ADDR_W-1 -: TAG_W];
    bit wrs = (wr && cmo[2:0] == 0) || cmo[3];
    bit nal = cmo[2:0] != 0;
    int hw = -1, ecode, eway = 0;
    string r;
    for (int w = 0; w < WAYS; w++) if (m_val[s][w] && m_tag[s][w] == t) hw = w;
    if (hw >= 0) begin
      ecode = 0; eway = hw;
      if (cmo[0] || cmo[2]) begin m_val[s][hw] = 0; m_dty[s][hw] = 0; end
      else begin
        m_touch(s, hw);
        if (cmo[1]) m_dty[s][hw] = 0; else if (wrs) m_dty[s][hw] = 1;
      end
    end else if (nal) ecode = 1;
    else begin
      int fr = -1;
      for (int w = WAYS - 1; w >= 0; w--) if (!m_val[s][w]) fr = w;
      if (fr >= 0) begin ecode = 1; eway = fr; end
      else begin eway = m_victim(s); ecode = m_dty[s][eway] ? 3 : 2; end
      m_tag[s][eway] = t; m_val[s][eway] = 1; m_dty[s][eway] = wrs; m_touch(s, eway);
    end
    if (lbl != "") r = lbl;
    else if (cmo[1]) r = "R7";
    else if (cmo[0] || cmo[2]) r = "R8";
    else if (cmo[3]) r = "R9";
    else if (ecode == 0) r = "R2";
    else if (ecode == 1) r = "R5";
    else r = "R6";
    req_addr = a; req_write = wr; req_cmo = cmo; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({r, " rsp_valid"}, int'(rsp_valid), 1);
    chk({r, " code"}, int'(rsp_code), ecode);
    chk({r, " way"}, int'(rsp_way), eway);
  endtask

  task automatic clear_all();
    inv_all = 1'b1;
    #1 chk("R10 ready low", int'(req_ready), 0);
    @(negedge clk);
    inv_all = 1'b0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin m_val[s][w] = 0; m_dty[s][w] = 0; end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset rsp_valid", int'(rsp_valid), 0);
    chk("R11 reset ready", int'(req_ready), 1);

    // R1: offset ignored
    do_req(mk(3, 0, 0), 1'b1, 4'b0000, "R1");
    do_req(mk(3, 0, 63), 1'b0, 4'b0000, "R1");
    chk("R1 same line hit", int'(rsp_code), 0);
    do_req(mk(3, 1, 5), 1'b0, 4'b0000, "R1");
    chk("R1 other set miss", int'(rsp_code), 1);
    @(negedge clk);
    chk("R11 idle no rsp", int'(rsp_valid), 0);

    // R4/R3/R6: fill set 2, dirty way 0, walk victims
    for (int k = 0; k < 4; k++) do_req(mk(1 + k, 2, 0), 1'b0, 4'b0000, "R5");
    do_req(mk(1, 2, 8), 1'b1, 4'b0000, "R3");
    do_req(mk(5, 2, 0), 1'b0, 4'b0000, "R4");
    chk("R4 victim way", int'(rsp_way), 2);
    do_req(mk(6, 2, 0), 1'b0, 4'b0000, "R4");
    chk("R4 victim way", int'(rsp_way), 1);
    do_req(mk(7, 2, 0), 1'b0, 4'b0000, "R4");
    chk("R4 victim way", int'(rsp_way), 3);
    do_req(mk(8, 2, 0), 1'b0, 4'b0000, "R3");
    chk("R3 dirty writeback code", int'(rsp_code), 3);
    chk("R6 dirty victim way", int'(rsp_way), 0);

    // R7: clean removes dirty, miss does not allocate
    do_req(mk(9, 3, 0), 1'b1, 4'b0000, "R7");
    do_req(mk(9, 3, 0), 1'b0, 4'b0010, "R7");
    for (int k = 0; k < 6; k++) do_req(mk(10 + k, 3, 0), 1'b0, 4'b0000, "R7");
    do_req(mk(30, 3, 0), 1'b0, 4'b0010, "R7");
    do_req(mk(30, 3, 0), 1'b0, 4'b0000, "R7");

    // R8: invalidate and flush
    do_req(mk(20, 4, 0), 1'b1, 4'b0000, "R8");
    do_req(mk(20, 4, 0), 1'b0, 4'b0001, "R8");
    do_req(mk(20, 4, 0), 1'b0, 4'b0000, "R8");
    chk("R8 refill after invalidate", int'(rsp_code), 1);
    do_req(mk(20, 4, 0), 1'b0, 4'b0100, "R8");
    do_req(mk(21, 4, 0), 1'b0, 4'b0100, "R8");
    do_req(mk(20, 4, 0), 1'b0, 4'b0000, "R8");

    // R9: zero allocates dirty
    do_req(mk(40, 5, 0), 1'b0, 4'b1000, "R9");
    do_req(mk(40, 5, 0), 1'b0, 4'b0000, "R9");

    // R10: whole clear
    clear_all();
    do_req(mk(40, 5, 0), 1'b0, 4'b0000, "R10");
    chk("R10 line gone", int'(rsp_code), 1);

    for (int i = 0; i < 3000; i++) begin
      int op = int'($urandom % 10);
      logic [3:0] c;
      logic [31:0] a = mk(int'($urandom % 8), int'($urandom % 4), int'($urandom % 64));
      case (op)
        6: c = 4'b1000;  7: c = 4'b0010;
        8: c = 4'b0001;  9: c = 4'b0100;
        default: c = 4'b0000;
      endcase
      if ($urandom % 80 == 0) clear_all();
      do_req(a, (op == 4 || op == 5) || ($urandom % 4 == 0), c, "");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule